// File: doc/BRIEF.md
# Horizontal Fine Scaler

This block resamples one video line in the horizontal direction. It has two lanes, one for luma and one for chroma. Each lane has its own input stream with a valid/ready handshake. A lane keeps a position counter in units of 1/1024 of an input sample. The counter starts at a programmable sub-sample offset and moves forward by a programmable step after every output pixel. The step is 1024 times the ratio of input to output pixels, so 1024 means unity, smaller steps zoom and larger steps shrink.

The integer part of the position decides which two neighbouring input samples are used. The upper six bits of the 10-bit fraction give one of 64 interpolation phases. The output is a two-tap linear blend of the two samples. When zooming, a lane holds its input stream stalled while it produces several outputs from the same sample pair. When shrinking, it takes input samples without producing output until it reaches the next position it needs.

The chroma lane runs on a 4:2:2 chroma line, which has half as many samples. For that reason its step and offset are programmed at half the luma values. An output pixel is emitted only when both lanes have the samples they need. Steps and offsets are captured when a line starts. Steps below the supported zoom limit are raised to that limit, and an error flag is set.

Top module: `hfsScaler`

## Requirements
- R1: After reset, `outValid`, `yReady`, `cReady` and `incErr` are all 0. No input is accepted until the first `lineStart` pulse.
- R2: When `lineStart` is high, each lane loads its position with its 8-bit offset times 32. One offset LSB is 1/32 of an input sample, and the position has 10 fraction bits. Output 0 therefore uses input samples floor(offset/32) and floor(offset/32)+1.
- R3: Each output equals (A*(64-p) + B*p + 32) >> 6. A and B are input samples floor(P) and floor(P)+1. P is the lane position. p is bits [9:4] of the 10-bit fraction of P.
- R4: After output k, the lane position becomes offset*32 + (k+1)*step. A step of 1024 returns the input samples unchanged.
- R5: When zooming (step < 1024), the lane keeps its ready low while it emits several outputs from the same sample pair. When shrinking (step > 1024), it accepts several samples between consecutive outputs.
- R6: The chroma lane has its own step, offset and input stream. `outValid` is high only in cycles where both lanes hold the pair for the current output.
- R7: A luma step below 293 is replaced by 293. A chroma step below 147 is replaced by 147. `incErr` shows, from the cycle after `lineStart`, whether either step was replaced at that line start.
- R8: Steps and offsets are sampled only in the `lineStart` cycle. Changing them mid-line has no effect on the outputs.
- R9: In the `lineStart` cycle, `yReady`, `cReady` and `outValid` are 0, and a sample presented in that cycle is not taken.
- R10: Once a lane needs a sample beyond those supplied for the line, no further output is produced until the next `lineStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle pulse that begins a line and captures steps and offsets |
| stepY | input | 13 | Luma step, 1024 × input/output ratio |
| stepC | input | 13 | Chroma step, half of the luma step |
| offsY | input | 8 | Luma start offset in 1/32 input sample |
| offsC | input | 8 | Chroma start offset in 1/32 input sample, half of the luma offset |
| yValid | input | 1 | Luma input sample valid |
| yData | input | 8 | Luma input sample |
| yReady | output | 1 | Luma lane takes a sample this cycle if valid |
| cValid | input | 1 | Chroma input sample valid |
| cData | input | 8 | Chroma input sample |
| cReady | output | 1 | Chroma lane takes a sample this cycle if valid |
| outValid | output | 1 | Output pixel valid |
| outY | output | 8 | Interpolated luma |
| outC | output | 8 | Interpolated chroma |
| incErr | output | 1 | A step was clamped at the last line start |

## Verification
The hardest states to reach are the extremes of the per-lane sample debt, because both lanes must be in them and they must meet different input gaps. One extreme is a large offset combined with the largest step, which makes a lane take up to eight samples between outputs. The other is the 3.5× zoom limit, which holds a lane stalled over many outputs. Directed lines pin these corners, and they include a step below the limit to trigger clamping. Random lines then vary the step, the offset, the line length and the valid gaps on each stream separately. The lane that finishes first must wait for the other, so its stall is exercised. Bogus data is kept valid during each `lineStart` cycle. Steps and offsets are scrambled during one line to show that they have no effect mid-line.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // line start: preset both lanes
    logic fire;   // an output pixel leaves this cycle
    logic takeY;  // luma lane shifts in a sample
    logic takeC;  // chroma lane shifts in a sample
  } hfsStrobe_t;
endpackage

// File: rtl/hfsLane.sv
module hfsLane #(
  parameter int DataW    = 8,
  parameter int IncW     = 13,
  parameter int FracW    = 10,
  parameter int PhaseW   = 6,
  parameter int OffW     = 8,
  parameter int OffFracW = 5,
  parameter int MinInc   = 293
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             take,
  input  logic             fire,
  input  logic [IncW-1:0]  incIn,
  input  logic [OffW-1:0]  offIn,
  input  logic [DataW-1:0] sampleIn,
  output logic             needSample,
  output logic [DataW-1:0] pixOut
);
  localparam int PosW     = OffW + FracW - OffFracW;
  localparam int CarryW   = IncW + 1 - FracW;
  localparam int DebtW    = CarryW + 1;
  localparam int WtW      = DataW + PhaseW + 1;
  localparam int Unity    = 1 << PhaseW;
  localparam int StartMax = (1 << (PosW - FracW)) + 1;
  localparam int CarryMax = (1 << CarryW) - 1;
  localparam int DebtMax  = (StartMax > CarryMax) ? StartMax : CarryMax;

  logic [FracW-1:0] frac;
  logic [DebtW-1:0] debt;
  logic [IncW-1:0]  incReg;
  logic [DataW-1:0] smpA, smpB;

  logic [PosW-1:0]   startPos;
  logic [DebtW-1:0]  startDebt;
  logic [IncW:0]     nextSum;
  logic [CarryW-1:0] carry;

  assign startPos  = {offIn, {(FracW - OffFracW){1'b0}}};
  assign startDebt = DebtW'(startPos[PosW-1:FracW]) + DebtW'(2);
  assign nextSum   = (IncW+1)'(frac) + (IncW+1)'(incReg);
  assign carry     = nextSum[IncW:FracW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frac   <= '0;
      debt   <= '0;
      incReg <= IncW'(MinInc);
      smpA   <= '0;
      smpB   <= '0;
    end else if (load) begin
      frac   <= startPos[FracW-1:0];
      debt   <= startDebt;
      incReg <= incIn;
    end else if (fire) begin
      frac <= nextSum[FracW-1:0];
      debt <= DebtW'(carry);
    end else if (take) begin
      debt <= debt - DebtW'(1);
      smpA <= smpB;
      smpB <= sampleIn;
    end
  end

  assign needSample = (debt != '0);

  logic [PhaseW-1:0] phase;
  logic [PhaseW:0]   wA;
  logic [WtW-1:0]    mix;

  assign phase  = frac[FracW-1 -: PhaseW];
  assign wA     = (PhaseW+1)'(Unity) - (PhaseW+1)'(phase);
  assign mix    = WtW'(smpA) * WtW'(wA) + WtW'(smpB) * WtW'(phase) + WtW'(Unity / 2);
  assign pixOut = mix[PhaseW +: DataW];

  // R7: the captured step never sits below the floor
  assert_inc_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(incReg) >= MinInc);
  // R5: emitting an output leaves the sample pair untouched
  assert_pair_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    fire && !load |=> $stable(smpA) && $stable(smpB));
  // R5: taking a sample leaves the phase untouched
  assert_frac_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    take && !load |=> $stable(frac));
  // R6: control fires only when this lane has its pair
  assert_fire_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> debt == '0);
  // R4: the sample debt stays within what one step can add
  assert_debt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(debt) <= DebtMax);
endmodule

// File: rtl/hfsDatapath.sv
module hfsDatapath import hfs_pkg::*; #(
  parameter int DataW    = 8,
  parameter int IncW     = 13,
  parameter int FracW    = 10,
  parameter int PhaseW   = 6,
  parameter int OffW     = 8,
  parameter int OffFracW = 5,
  parameter int MinIncY  = 293,
  parameter int MinIncC  = 147
) (
  input  logic             clk,
  input  logic             rstN,
  input  hfsStrobe_t       strobe,
  input  logic [IncW-1:0]  stepY,
  input  logic [IncW-1:0]  stepC,
  input  logic [OffW-1:0]  offsY,
  input  logic [OffW-1:0]  offsC,
  input  logic [DataW-1:0] yData,
  input  logic [DataW-1:0] cData,
  output logic             needY,
  output logic             needC,
  output logic [DataW-1:0] outY,
  output logic [DataW-1:0] outC
);
  localparam int Lanes = 2;

  logic [Lanes-1:0][IncW-1:0]  stepArr;
  logic [Lanes-1:0][OffW-1:0]  offArr;
  logic [Lanes-1:0][DataW-1:0] dataArr;
  logic [Lanes-1:0][DataW-1:0] pixArr;
  logic [Lanes-1:0]            takeArr;
  logic [Lanes-1:0]            needArr;

  assign stepArr = {stepC, stepY};
  assign offArr  = {offsC, offsY};
  assign dataArr = {cData, yData};
  assign takeArr = {strobe.takeC, strobe.takeY};

  for (genvar g = 0; g < Lanes; g++) begin : gLane
    localparam int LaneMin = (g == 0) ? MinIncY : MinIncC;
    hfsLane #(
      .DataW(DataW), .IncW(IncW), .FracW(FracW), .PhaseW(PhaseW),
      .OffW(OffW), .OffFracW(OffFracW), .MinInc(LaneMin)
    ) u_lane (
      .clk       (clk),
      .rstN      (rstN),
      .load      (strobe.load),
      .take      (takeArr[g]),
      .fire      (strobe.fire),
      .incIn     (stepArr[g]),
      .offIn     (offArr[g]),
      .sampleIn  (dataArr[g]),
      .needSample(needArr[g]),
      .pixOut    (pixArr[g])
    );
  end

  assign needY = needArr[0];
  assign needC = needArr[1];
  assign outY  = pixArr[0];
  assign outC  = pixArr[1];
endmodule

// File: rtl/hfsControl.sv
module hfsControl import hfs_pkg::*; #(
  parameter int IncW    = 13,
  parameter int MinIncY = 293,
  parameter int MinIncC = 147
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lineStart,
  input  logic            yValid,
  input  logic            cValid,
  input  logic            needY,
  input  logic            needC,
  input  logic [IncW-1:0] stepYIn,
  input  logic [IncW-1:0] stepCIn,
  output logic [IncW-1:0] stepYUse,
  output logic [IncW-1:0] stepCUse,
  output logic            yReady,
  output logic            cReady,
  output logic            outValid,
  output logic            incErr,
  output hfsStrobe_t      strobe
);
  logic active;
  logic lowY, lowC;

  assign lowY     = stepYIn < IncW'(MinIncY);
  assign lowC     = stepCIn < IncW'(MinIncC);
  assign stepYUse = lowY ? IncW'(MinIncY) : stepYIn;
  assign stepCUse = lowC ? IncW'(MinIncC) : stepCIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      incErr <= 1'b0;
    end else if (lineStart) begin
      active <= 1'b1;
      incErr <= lowY | lowC;
    end
  end

  assign yReady   = active && !lineStart && needY;
  assign cReady   = active && !lineStart && needC;
  assign outValid = active && !lineStart && !needY && !needC;

  assign strobe.load  = lineStart;
  assign strobe.fire  = outValid;
  assign strobe.takeY = yValid && yReady;
  assign strobe.takeC = cValid && cReady;

  // R9: nothing moves in a line-start cycle
  assert_start_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |-> !yReady && !cReady && !outValid);
  // R7: the error flag only rises after a line start
  assert_err_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(incErr) |-> $past(lineStart));
  // R6: an output cycle never takes input on either lane
  assert_no_take_on_fire_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !strobe.takeY && !strobe.takeC);
  // R1: before the first line the block stays idle
  assert_idle_before_line_R1: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !yReady && !cReady && !outValid);
endmodule

// File: rtl/hfsScaler.sv
module hfsScaler import hfs_pkg::*; #(
  parameter int DataW    = 8,
  parameter int IncW     = 13,
  parameter int FracW    = 10,
  parameter int PhaseW   = 6,
  parameter int OffW     = 8,
  parameter int OffFracW = 5,
  parameter int MinIncY  = 293
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic [IncW-1:0]  stepY,
  input  logic [IncW-1:0]  stepC,
  input  logic [OffW-1:0]  offsY,
  input  logic [OffW-1:0]  offsC,
  input  logic             yValid,
  input  logic [DataW-1:0] yData,
  output logic             yReady,
  input  logic             cValid,
  input  logic [DataW-1:0] cData,
  output logic             cReady,
  output logic             outValid,
  output logic [DataW-1:0] outY,
  output logic [DataW-1:0] outC,
  output logic             incErr
);
  localparam int MinIncC = (MinIncY + 1) / 2;

  hfsStrobe_t      strobe;
  logic            needY, needC;
  logic [IncW-1:0] stepYUse, stepCUse;

  hfsControl #(.IncW(IncW), .MinIncY(MinIncY), .MinIncC(MinIncC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineStart(lineStart),
    .yValid   (yValid),
    .cValid   (cValid),
    .needY    (needY),
    .needC    (needC),
    .stepYIn  (stepY),
    .stepCIn  (stepC),
    .stepYUse (stepYUse),
    .stepCUse (stepCUse),
    .yReady   (yReady),
    .cReady   (cReady),
    .outValid (outValid),
    .incErr   (incErr),
    .strobe   (strobe)
  );

  hfsDatapath #(
    .DataW(DataW), .IncW(IncW), .FracW(FracW), .PhaseW(PhaseW),
    .OffW(OffW), .OffFracW(OffFracW), .MinIncY(MinIncY), .MinIncC(MinIncC)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .stepY (stepYUse),
    .stepC (stepCUse),
    .offsY (offsY),
    .offsC (offsC),
    .yData (yData),
    .cData (cData),
    .needY (needY),
    .needC (needC),
    .outY  (outY),
    .outC  (outC)
  );
endmodule

// File: tb/test_hfsScaler.sv
module test_hfsScaler;
  localparam int ClkPeriod = 10;
  localparam int FloorY = 293;
  localparam int FloorC = 147;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStart = 1'b0;
  logic [12:0] stepY = 13'd1024, stepC = 13'd512;
  logic [7:0] offsY = 8'd0, offsC = 8'd0;
  logic yValid = 1'b0, cValid = 1'b0;
  logic [7:0] yData = 8'd0, cData = 8'd0;
  logic yReady, cReady, outValid, incErr;
  logic [7:0] outY, outC;

  int total = 0;
  int bad = 0;
  int lumaLine[64];
  int chromaLine[32];
  int curIncY, curIncC, curOffY, curOffC;

  always #(ClkPeriod/2) clk = ~clk;

  hfsScaler i_hfsScaler (
    .clk(clk), .rstN(rstN), .lineStart(lineStart),
    .stepY(stepY), .stepC(stepC), .offsY(offsY), .offsC(offsC),
    .yValid(yValid), .yData(yData), .yReady(yReady),
    .cValid(cValid), .cData(cData), .cReady(cReady),
    .outValid(outValid), .outY(outY), .outC(outC), .incErr(incErr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int posOf(int off, int inc, int k);
    return off * 32 + k * inc;
  endfunction

  function automatic int expPix(bit chroma, int k);
    int pos, idx, ph, a, b;
    pos = chroma ? posOf(curOffC, curIncC, k) : posOf(curOffY, curIncY, k);
    idx = pos >> 10;
    ph  = (pos >> 4) & 63;
    a = chroma ? chromaLine[idx] : lumaLine[idx];
    b = chroma ? chromaLine[idx+1] : lumaLine[idx+1];
    return (a * (64 - ph) + b * ph + 32) >> 6;
  endfunction

  function automatic int countOut(int off, int inc, int len);
    int k = 0;
    while ((posOf(off, inc, k) >> 10) + 1 <= len - 1) k++;
    return k;
  endfunction

  task automatic runLine(input string tag, input int n, input int iY, input int oY,
                         input int iC, input int oC, input bit perturb, input int gap);
    int nc, ec, yi, ci, got, tail, cy, cc;
    bit expErr;
    nc = n / 2;
    for (int i = 0; i < n; i++) lumaLine[i] = int'($urandom_range(255));
    for (int i = 0; i < nc; i++) chromaLine[i] = int'($urandom_range(255));
    curIncY = (iY < FloorY) ? FloorY : iY;
    curIncC = (iC < FloorC) ? FloorC : iC;
    curOffY = oY;
    curOffC = oC;
    expErr = (iY < FloorY) || (iC < FloorC);
    cy = countOut(oY, curIncY, n);
    cc = countOut(oC, curIncC, nc);
    ec = (cy < cc) ? cy : cc;

    @(negedge clk);
    lineStart = 1'b1;
    stepY = 13'(iY); stepC = 13'(iC); offsY = 8'(oY); offsC = 8'(oC);
    yValid = 1'b1; yData = 8'hEE; cValid = 1'b1; cData = 8'hEE;
    #1;
    // R9: quiet line-start cycle, bogus samples must not be taken
    chk(yReady === 1'b0 && cReady === 1'b0 && outValid === 1'b0, "R9",
        "ready/valid in line-start cycle", int'({yReady, cReady, outValid}), 0);
    @(negedge clk);
    lineStart = 1'b0;
    chk(incErr === expErr, "R7", "incErr after line start", int'(incErr), int'(expErr));

    yi = 0; ci = 0; got = 0; tail = 0;
    for (int cyc = 0; cyc < 4000 && tail < 12; cyc++) begin
      if (perturb) begin
        stepY = 13'($urandom); stepC = 13'($urandom);
        offsY = 8'($urandom);  offsC = 8'($urandom);
      end
      yValid = (yi < n) && ($urandom_range(99) >= 32'(gap));
      yData  = 8'(lumaLine[(yi < n) ? yi : 0]);
      cValid = (ci < nc) && ($urandom_range(99) >= 32'(gap));
      cData  = 8'(chromaLine[(ci < nc) ? ci : 0]);
      #1;
      if (outValid) begin
        if (got < ec) begin
          chk(int'(outY) == expPix(1'b0, got), tag, "luma output", int'(outY), expPix(1'b0, got));
          chk(int'(outC) == expPix(1'b1, got), tag, "chroma output", int'(outC), expPix(1'b1, got));
        end else begin
          chk(1'b0, "R10", "output past end of line", got, ec);
        end
        got++;
      end
      if (yValid && yReady) yi++;
      if (cValid && cReady) ci++;
      if (got >= ec) tail++;
      @(negedge clk);
    end
    yValid = 1'b0;
    cValid = 1'b0;
    chk(got == ec, tag, "output count", got, ec);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R10 act=190000 exp=<190000 cycles");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4711));
    yValid = 1'b1;
    cValid = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1: idle state after reset, input offered but not taken
    chk(outValid === 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    chk(yReady === 1'b0 && cReady === 1'b0, "R1", "ready after reset", int'({yReady, cReady}), 0);
    chk(incErr === 1'b0, "R1", "incErr after reset", int'(incErr), 0);
    yValid = 1'b0;
    cValid = 1'b0;

    // R4: unity step passes samples through
    runLine("R4", 16, 1024, 0, 512, 0, 1'b0, 0);
    // R2: start offset of 1.25 samples
    runLine("R2", 24, 1024, 40, 512, 20, 1'b0, 10);
    // R5: largest zoom
    runLine("R5", 20, 293, 0, 147, 0, 1'b0, 20);
    // R5: strongest shrink with a large offset
    runLine("R5", 64, 8191, 255, 4095, 127, 1'b0, 0);
    // R7: steps below the floor are clamped
    runLine("R7", 16, 100, 3, 10, 1, 1'b0, 5);
    // R8: registers scrambled mid-line
    runLine("R8", 32, 700, 77, 350, 38, 1'b1, 15);
    // R6: lanes with different input gaps
    runLine("R6", 30, 1500, 9, 750, 4, 1'b0, 45);
    // R3: random lines
    for (int l = 0; l < 10; l++) begin
      int iY, oY, n;
      iY = int'($urandom_range(8191, 293));
      oY = int'($urandom_range(255));
      n  = 2 * int'($urandom_range(32, 10));
      runLine("R3", n, iY, oY, iY / 2, oY / 2, 1'b0, int'($urandom_range(50)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule